// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive monitor for the command bus of a two-rank SDRAM in which each rank has four internal banks. It samples the shared row strobe, column strobe and write-enable pins on every rising clock edge. It samples each rank's select and clock enable on the same edge. From these it decodes the command each rank has accepted. For every bank it tracks whether a row is open and how many clocks have passed since the bank was last activated and last closed. For every rank it tracks the last mode register write, the last activate and progress through the power-up sequence. It drives nothing on the memory bus.

When a command breaks a clock-count rule or a state rule, the monitor raises a one-cycle violation pulse. With the pulse it gives an error code and a flat bank index (rank times bank count plus bank). The limits are parameters. The defaults match a CAS-latency-3 speed grade (3/3/9/6/2/2 clocks), and the CAS-latency-2 set (2/2/6/4 clocks) can be loaded instead. The monitor sits beside a memory controller in simulation or on silicon and flags protocol slips as they happen.

Top module: `sdram_timing_monitor`

## Requirements
- R1: Decoding uses {row_strobe_n, col_strobe_n, wr_en_n}: 011 activate, 101 read, 100 write, 010 precharge (ap_bit high = all banks), 001 auto refresh, 000 mode register set, 110 burst stop, 111 no-op. A rank accepts a command only when its sel_n bit is low and its rank_clk_en bit is high. A rank that does not accept the command reports nothing for it and its state is left unchanged, but its timers keep counting. No-op is never flagged.
- R2: The outputs are registered. A violation by the command sampled at edge k shows on viol, viol_code and viol_bank from edge k until edge k+1. In any cycle without a violation, and after reset, all three outputs are zero.
- R3: Code 1 is raised for any command other than no-op that reaches a rank fewer than T_MRD clocks after that rank's mode register set.
- R4: Code 2 is raised for a mode register set to a rank that has not yet seen a precharge-all followed by INIT_REFS auto refreshes. A precharge-all that comes before the sequence completes restarts the count, and a completed sequence stays complete until reset.
- R5: A read or write to a bank with no open row gives code 3. A read or write fewer than T_RCD clocks after that bank's activate gives code 4.
- R6: For an activate, an already open bank gives code 5. Fewer than T_RP clocks since the bank closed gives code 6. Fewer than T_RC clocks since the bank's previous activate gives code 7.
- R7: An activate fewer than T_RRD clocks after an activate to a different bank of the same rank gives code 8.
- R8: A precharge that closes an open bank fewer than T_RAS clocks after its activate gives code 9. Precharging a bank that is already closed has no effect.
- R9: An auto refresh to a rank that still has an open bank gives code 10.
- R10: A read or write with ap_bit high closes its bank, and T_RP for that bank counts from that command.
- R11: At most one violation is reported per cycle. Within a command the lowest applicable code wins, and rank 0 wins over rank 1. The bank part of viol_bank is bank_addr for activate, read, write and single-bank precharge. For precharge-all and refresh it is the lowest offending bank, and otherwise it is 0. State is updated for flagged commands exactly as for legal ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | RANKS | Per-rank select, active low |
| rank_clk_en | input | RANKS | Per-rank clock enable, active high |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_addr | input | log2(BANKS) | Bank address |
| ap_bit | input | 1 | Address bit 10: auto-precharge / precharge-all |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Error code of the reported violation |
| viol_bank | output | log2(RANKS*BANKS) | Flat index rank*BANKS+bank |

## Verification
Every result comes out of one register stage. A command driven before rising edge k is judged on that edge, and its code and bank index are valid from edge k until edge k+1. The bench drives each command on a falling edge and compares all three outputs on the next falling edge, half a period after the judging edge. Its timing model moves forward by exactly one command per compare, so the distances in clocks that it works out match the edges the design counts.

// File: rtl/smon_pkg.sv
package smon_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE   = 4'd0,
    E_MRD    = 4'd1,
    E_INIT   = 4'd2,
    E_CLOSED = 4'd3,
    E_RCD    = 4'd4,
    E_OPEN   = 4'd5,
    E_RP     = 4'd6,
    E_RC     = 4'd7,
    E_RRD    = 4'd8,
    E_RAS    = 4'd9,
    E_REFOPN = 4'd10
  } err_e;

  function automatic cmd_e decode_cmd(input logic rs_n, input logic cs_n, input logic we_n);
    case ({rs_n, cs_n, we_n})
      3'b011:  return C_ACT;
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      3'b000:  return C_MRS;
      3'b110:  return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/smon_bank_track.sv
module smon_bank_track
  import smon_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  parameter int T_RAS = 6
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  input  logic hit,
  input  logic ap,
  output err_e err
);

  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS);

  logic [CNT_W-1:0] since_act;
  logic [CNT_W-1:0] since_close;
  logic             open_q;
  logic             opening;
  logic             closing;

  assign opening = hit && (cmd == C_ACT);
  assign closing = open_q &&
                   (((cmd == C_PRE) && (hit || ap)) ||
                    (((cmd == C_RD) || (cmd == C_WR)) && hit && ap));

  always_comb begin
    err = E_NONE;
    case (cmd)
      C_ACT: if (hit) begin
        if (open_q)                  err = E_OPEN;
        else if (since_close < L_RP) err = E_RP;
        else if (since_act < L_RC)   err = E_RC;
      end
      C_RD, C_WR: if (hit) begin
        if (!open_q)                 err = E_CLOSED;
        else if (since_act < L_RCD)  err = E_RCD;
      end
      C_PRE: if ((hit || ap) && open_q && (since_act < L_RAS)) err = E_RAS;
      C_REF: if (open_q) err = E_REFOPN;
      default: err = E_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      since_act   <= '1;
      since_close <= '1;
    end else begin
      since_act   <= opening ? CNT_W'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
      since_close <= closing ? CNT_W'(1) : ((since_close == '1) ? since_close : since_close + 1'b1);
      if (opening)      open_q <= 1'b1;
      else if (closing) open_q <= 1'b0;
    end
  end

endmodule

// File: rtl/smon_rank_track.sv
module smon_rank_track
  import smon_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int BA_W      = 2,
  parameter int CNT_W     = 5,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RAS     = 6,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            rs_n,
  input  logic            cs_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            ap,
  output err_e            err,
  output logic [BA_W-1:0] err_bank
);

  localparam int IW = $clog2(INIT_REFS + 2);
  localparam logic [IW-1:0]    INIT_DONE = IW'(INIT_REFS + 1);
  localparam logic [CNT_W-1:0] L_RRD     = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] L_MRD     = CNT_W'(T_MRD);

  cmd_e             cmd;
  err_e             bank_err [BANKS];
  err_e             low_err;
  logic [BA_W-1:0]  low_bank;
  logic [CNT_W-1:0] since_mrs;
  logic [CNT_W-1:0] since_any_act;
  logic [BA_W-1:0]  last_act_bank;
  logic [IW-1:0]    init_cnt;
  logic             init_done;
  logic             targeted;

  assign cmd       = accept ? decode_cmd(rs_n, cs_n, we_n) : C_NOP;
  assign init_done = (init_cnt == INIT_DONE);
  assign targeted  = (cmd == C_ACT) || (cmd == C_RD) || (cmd == C_WR) ||
                     ((cmd == C_PRE) && !ap);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    smon_bank_track #(
      .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS)
    ) u_bank (
      .clk (clk),
      .rst (rst),
      .cmd (cmd),
      .hit (ba == BA_W'(b)),
      .ap  (ap),
      .err (bank_err[b])
    );
  end

  always_comb begin
    low_err  = E_NONE;
    low_bank = '0;
    for (int b = BANKS - 1; b >= 0; b--) begin
      if (bank_err[b] != E_NONE) begin
        low_err  = bank_err[b];
        low_bank = BA_W'(b);
      end
    end
  end

  always_comb begin
    err      = E_NONE;
    err_bank = '0;
    if (cmd != C_NOP) begin
      if (since_mrs < L_MRD) begin
        err      = E_MRD;
        err_bank = targeted ? ba : '0;
      end else begin
        case (cmd)
          C_MRS: if (!init_done) err = E_INIT;
          C_RD, C_WR: begin
            err      = bank_err[ba];
            err_bank = ba;
          end
          C_ACT: begin
            err      = bank_err[ba];
            err_bank = ba;
            if ((err == E_NONE) && (since_any_act < L_RRD) && (last_act_bank != ba))
              err = E_RRD;
          end
          C_PRE: begin
            if (!ap) begin
              err      = bank_err[ba];
              err_bank = ba;
            end else begin
              err      = low_err;
              err_bank = low_bank;
            end
          end
          C_REF: begin
            err      = low_err;
            err_bank = low_bank;
          end
          default: err = E_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_mrs     <= '1;
      since_any_act <= '1;
      last_act_bank <= '0;
      init_cnt      <= '0;
    end else begin
      since_mrs <= (cmd == C_MRS) ? CNT_W'(1)
                 : ((since_mrs == '1) ? since_mrs : since_mrs + 1'b1);
      since_any_act <= (cmd == C_ACT) ? CNT_W'(1)
                     : ((since_any_act == '1) ? since_any_act : since_any_act + 1'b1);
      if (cmd == C_ACT) last_act_bank <= ba;
      if (!init_done) begin
        if ((cmd == C_PRE) && ap)
          init_cnt <= IW'(1);
        else if ((cmd == C_REF) && (init_cnt != '0))
          init_cnt <= init_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_timing_monitor.sv
module sdram_timing_monitor
  import smon_pkg::*;
#(
  parameter int RANKS     = 2,
  parameter int BANKS     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RAS     = 6,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 2,
  localparam int BA_W     = $clog2(BANKS),
  localparam int IDX_W    = $clog2(RANKS * BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RANKS-1:0]  sel_n,
  input  logic [RANKS-1:0]  rank_clk_en,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_en_n,
  input  logic [BA_W-1:0]   bank_addr,
  input  logic              ap_bit,
  output logic              viol,
  output logic [3:0]        viol_code,
  output logic [IDX_W-1:0]  viol_bank
);

  localparam int T_MAX = max2(max2(max2(T_RCD, T_RP), max2(T_RC, T_RAS)),
                              max2(T_RRD, T_MRD));
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;

  err_e            rank_err  [RANKS];
  logic [BA_W-1:0] rank_bank [RANKS];
  err_e            pick_err;
  logic [IDX_W-1:0] pick_idx;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    smon_rank_track #(
      .BANKS(BANKS), .BA_W(BA_W), .CNT_W(CNT_W),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS),
      .T_RRD(T_RRD), .T_MRD(T_MRD), .INIT_REFS(INIT_REFS)
    ) u_rank (
      .clk      (clk),
      .rst      (rst),
      .accept   (!sel_n[r] && rank_clk_en[r]),
      .rs_n     (row_strobe_n),
      .cs_n     (col_strobe_n),
      .we_n     (wr_en_n),
      .ba       (bank_addr),
      .ap       (ap_bit),
      .err      (rank_err[r]),
      .err_bank (rank_bank[r])
    );
  end

  always_comb begin
    pick_err = E_NONE;
    pick_idx = '0;
    for (int r = RANKS - 1; r >= 0; r--) begin
      if (rank_err[r] != E_NONE) begin
        pick_err = rank_err[r];
        pick_idx = IDX_W'(r * BANKS) + IDX_W'(rank_bank[r]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= '0;
      viol_bank <= '0;
    end else begin
      viol      <= (pick_err != E_NONE);
      viol_code <= pick_err;
      viol_bank <= pick_idx;
    end
  end

endmodule

// File: rtl/sdram_timing_monitor_chk.sv
module sdram_timing_monitor_chk #(
  parameter int RANKS = 2,
  parameter int BA_W  = 2,
  parameter int IDX_W = 3,
  parameter int T_RCD = 3,
  parameter int T_MRD = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [RANKS-1:0] sel_n,
  input logic [RANKS-1:0] rank_clk_en,
  input logic             row_strobe_n,
  input logic             col_strobe_n,
  input logic             wr_en_n,
  input logic [BA_W-1:0]  bank_addr,
  input logic             viol,
  input logic [3:0]       viol_code,
  input logic [IDX_W-1:0] viol_bank
);

  logic r0_acc, r0_mrs, r0_any, r0_act, r0_rw, all_nop, none_acc;

  assign r0_acc   = !sel_n[0] && rank_clk_en[0];
  assign all_nop  = row_strobe_n && col_strobe_n && wr_en_n;
  assign none_acc = &(sel_n | ~rank_clk_en);
  assign r0_mrs   = r0_acc && !row_strobe_n && !col_strobe_n && !wr_en_n;
  assign r0_any   = r0_acc && !all_nop;
  assign r0_act   = r0_acc && !row_strobe_n && col_strobe_n && wr_en_n;
  assign r0_rw    = r0_acc && row_strobe_n && !col_strobe_n;

  // R1
  deselected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    none_acc |=> !viol);

  // R1
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    all_nop |=> !viol);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !viol |-> (viol_code == 4'd0) && (viol_bank == '0));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    viol |-> (viol_code != 4'd0) && (viol_code <= 4'd10));

  // R3
  mrs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (r0_mrs && (T_MRD >= 2)) ##1 r0_any |=> viol && (viol_code == 4'd1));

  // R5
  act_to_rw_chk: assert property (@(posedge clk) disable iff (rst)
    (r0_act && (T_RCD >= 2)) ##1 (r0_rw && (bank_addr == $past(bank_addr))) |=> viol);

endmodule

bind sdram_timing_monitor sdram_timing_monitor_chk #(
  .RANKS(RANKS), .BA_W(BA_W), .IDX_W(IDX_W), .T_RCD(T_RCD), .T_MRD(T_MRD)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sel_n        (sel_n),
  .rank_clk_en  (rank_clk_en),
  .row_strobe_n (row_strobe_n),
  .col_strobe_n (col_strobe_n),
  .wr_en_n      (wr_en_n),
  .bank_addr    (bank_addr),
  .viol         (viol),
  .viol_code    (viol_code),
  .viol_bank    (viol_bank)
);

// File: tb/test_sdram_timing_monitor.sv
module test_sdram_timing_monitor;

  localparam int RANKS = 2, BANKS = 4;
  localparam int T_RCD = 3, T_RP = 3, T_RC = 9, T_RAS = 6, T_RRD = 2, T_MRD = 2;
  localparam int INIT_REFS = 2;
  localparam int BA_W = $clog2(BANKS), IDX_W = $clog2(RANKS * BANKS);
  localparam int SAT = 1000;

  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100, K_PRE = 3'b010;
  localparam logic [2:0] K_REF = 3'b001, K_MRS = 3'b000, K_BST = 3'b110, K_NOP = 3'b111;

  logic clk = 1'b0, rst = 1'b1;
  logic [RANKS-1:0] sel_n = '1, rank_clk_en = '1;
  logic row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1, ap_bit = 1'b0;
  logic [BA_W-1:0] bank_addr = '0;
  logic viol;
  logic [3:0] viol_code;
  logic [IDX_W-1:0] viol_bank;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  int m_open [RANKS][BANKS];
  int m_sa   [RANKS][BANKS];
  int m_sp   [RANKS][BANKS];
  int m_smrs [RANKS];
  int m_sact [RANKS];
  int m_last [RANKS];
  int m_init [RANKS];

  always #10 clk = ~clk;

  sdram_timing_monitor #(
    .RANKS(RANKS), .BANKS(BANKS), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
    .T_RAS(T_RAS), .T_RRD(T_RRD), .T_MRD(T_MRD), .INIT_REFS(INIT_REFS)
  ) i_sdram_timing_monitor (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rank_clk_en(rank_clk_en),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
    .bank_addr(bank_addr), .ap_bit(ap_bit),
    .viol(viol), .viol_code(viol_code), .viol_bank(viol_bank)
  );

  task automatic model_reset();
    for (int r = 0; r < RANKS; r++) begin
      for (int b = 0; b < BANKS; b++) begin
        m_open[r][b] = 0; m_sa[r][b] = SAT; m_sp[r][b] = SAT;
      end
      m_smrs[r] = SAT; m_sact[r] = SAT; m_last[r] = 0; m_init[r] = 0;
    end
  endtask

  function automatic int model_eval(input int r, input logic [2:0] k, input int b,
                                    input logic a, output int bk);
    int e;
    e = 0; bk = 0;
    if (k == K_NOP) return 0;
    if (m_smrs[r] < T_MRD) begin
      bk = (k == K_ACT || k == K_RD || k == K_WR || (k == K_PRE && !a)) ? b : 0;
      return 1;
    end
    case (k)
      K_MRS: if (m_init[r] != INIT_REFS + 1) e = 2;
      K_RD, K_WR: begin
        bk = b;
        if (m_open[r][b] == 0) e = 3;
        else if (m_sa[r][b] < T_RCD) e = 4;
      end
      K_ACT: begin
        bk = b;
        if (m_open[r][b] != 0) e = 5;
        else if (m_sp[r][b] < T_RP) e = 6;
        else if (m_sa[r][b] < T_RC) e = 7;
        else if (m_sact[r] < T_RRD && m_last[r] != b) e = 8;
      end
      K_PRE: begin
        if (!a) begin
          bk = b;
          if (m_open[r][b] != 0 && m_sa[r][b] < T_RAS) e = 9;
        end else begin
          for (int i = BANKS - 1; i >= 0; i--)
            if (m_open[r][i] != 0 && m_sa[r][i] < T_RAS) begin e = 9; bk = i; end
        end
      end
      K_REF: for (int i = BANKS - 1; i >= 0; i--)
               if (m_open[r][i] != 0) begin e = 10; bk = i; end
      default: e = 0;
    endcase
    return e;
  endfunction

  task automatic model_update(input int r, input logic [2:0] k, input int b, input logic a);
    for (int i = 0; i < BANKS; i++) begin
      if (m_sa[r][i] < SAT) m_sa[r][i]++;
      if (m_sp[r][i] < SAT) m_sp[r][i]++;
    end
    if (m_smrs[r] < SAT) m_smrs[r]++;
    if (m_sact[r] < SAT) m_sact[r]++;
    case (k)
      K_ACT: begin m_open[r][b] = 1; m_sa[r][b] = 1; m_sact[r] = 1; m_last[r] = b; end
      K_RD, K_WR: if (a && m_open[r][b] != 0) begin m_open[r][b] = 0; m_sp[r][b] = 1; end
      K_PRE: begin
        for (int i = 0; i < BANKS; i++)
          if ((a || i == b) && m_open[r][i] != 0) begin m_open[r][i] = 0; m_sp[r][i] = 1; end
        if (a && m_init[r] != INIT_REFS + 1) m_init[r] = 1;
      end
      K_REF: if (m_init[r] >= 1 && m_init[r] <= INIT_REFS) m_init[r]++;
      K_MRS: m_smrs[r] = 1;
      default: ;
    endcase
  endtask

  task automatic compare(input logic ev, input int ec, input int eb, input string tag);
    vectors++;
    if (viol !== ev || viol_code !== 4'(ec) || viol_bank !== IDX_W'(eb)) begin
      miscompares++;
      $display("FAIL %s: viol=%0b code=%0d bank=%0d expected viol=%0b code=%0d bank=%0d",
               tag, viol, viol_code, viol_bank, ev, ec, eb);
    end
  endtask

  task automatic apply(input logic [RANKS-1:0] csn, input logic [RANKS-1:0] ck,
                       input logic [2:0] k, input int b, input logic a, input string tag);
    int ec, eb, e, rb;
    logic [2:0] kk;
    sel_n = csn; rank_clk_en = ck; {row_strobe_n, col_strobe_n, wr_en_n} = k;
    bank_addr = BA_W'(b); ap_bit = a;
    ec = 0; eb = 0;
    for (int r = RANKS - 1; r >= 0; r--) begin
      kk = (!csn[r] && ck[r]) ? k : K_NOP;
      e = model_eval(r, kk, b, a, rb);
      if (e != 0) begin ec = e; eb = r * BANKS + rb; end
    end
    for (int r = 0; r < RANKS; r++) begin
      kk = (!csn[r] && ck[r]) ? k : K_NOP;
      model_update(r, kk, b, a);
    end
    @(posedge clk);
    @(negedge clk);
    compare(ec != 0, ec, eb, tag);
  endtask

  task automatic cmd0(input logic [2:0] k, input int b, input logic a, input string tag);
    apply(2'b10, 2'b11, k, b, a, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) apply('1, '1, K_NOP, 0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; sel_n = '1; rank_clk_en = '1;
    {row_strobe_n, col_strobe_n, wr_en_n} = K_NOP;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int unsigned seed_ret;
    seed_ret = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();
    compare(1'b0, 0, 0, "R2 reset state");

    // R4 mode set before init, then the init sequence
    cmd0(K_MRS, 0, 1'b0, "R4 early mode set");
    idle(1, "R3 gap");
    cmd0(K_PRE, 0, 1'b1, "R4 precharge-all");
    cmd0(K_REF, 0, 1'b0, "R4 refresh 1");
    cmd0(K_REF, 0, 1'b0, "R4 refresh 2");
    cmd0(K_MRS, 0, 1'b0, "R4 legal mode set");
    cmd0(K_BST, 0, 1'b0, "R3 command right after mode set");
    idle(1, "R3 gap");
    cmd0(K_ACT, 1, 1'b0, "R6 legal activate");
    cmd0(K_ACT, 2, 1'b0, "R7 activate spacing");
    cmd0(K_RD, 1, 1'b0, "R5 read too soon");
    cmd0(K_RD, 3, 1'b0, "R5 read closed bank");
    cmd0(K_PRE, 1, 1'b0, "R8 precharge too soon");
    cmd0(K_ACT, 1, 1'b0, "R6 activate after close");
    cmd0(K_REF, 0, 1'b0, "R9 refresh with open banks");
    cmd0(K_ACT, 2, 1'b0, "R6 activate open bank");
    idle(10, "R2 quiet");
    cmd0(K_PRE, 0, 1'b0, "R8 precharge closed bank");
    cmd0(K_ACT, 0, 1'b0, "R8 closed-bank precharge had no effect");
    idle(3, "R2 quiet");
    cmd0(K_RD, 0, 1'b1, "R10 read with auto-precharge");
    cmd0(K_ACT, 0, 1'b0, "R10 activate after auto-precharge");
    idle(12, "R2 quiet");
    cmd0(K_ACT, 3, 1'b0, "R6 open for row cycle test");
    idle(2, "R2 quiet");
    cmd0(K_WR, 3, 1'b1, "R10 write with auto-precharge");
    idle(2, "R2 quiet");
    cmd0(K_ACT, 3, 1'b0, "R6 row cycle too short");

    // R1 deselected and clock-disabled ranks, R11 rank priority
    do_reset();
    apply(2'b01, 2'b01, K_ACT, 0, 1'b0, "R1 rank1 clock disabled");
    apply(2'b01, 2'b11, K_RD, 0, 1'b0, "R1 rank1 bank still closed");
    apply(2'b11, 2'b11, K_MRS, 0, 1'b0, "R1 deselected mode set");
    idle(2, "R2 quiet");
    apply(2'b00, 2'b11, K_RD, 2, 1'b0, "R11 both ranks, rank0 wins");
    apply(2'b00, 2'b11, K_MRS, 0, 1'b0, "R11 both ranks init error");
    idle(2, "R2 quiet");

    // R11 random mix checked against the model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int unsigned x, y;
      logic [RANKS-1:0] cs, ck;
      logic [2:0] k;
      x = $urandom % 100;
      if (x < 40)      cs = 2'b10;
      else if (x < 75) cs = 2'b01;
      else if (x < 85) cs = 2'b00;
      else             cs = 2'b11;
      ck = ($urandom % 10 == 0) ? RANKS'($urandom) : '1;
      y = $urandom % 100;
      if (y < 30)      k = K_NOP;
      else if (y < 50) k = K_ACT;
      else if (y < 60) k = K_RD;
      else if (y < 68) k = K_WR;
      else if (y < 82) k = K_PRE;
      else if (y < 90) k = K_REF;
      else if (y < 95) k = K_MRS;
      else             k = K_BST;
      apply(cs, ck, k, int'($urandom % BANKS), logic'($urandom % 2), "R11 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule